// File: doc/BRIEF.md
# Overload Fault Integrator with Latched or Auto-Recovery Shutdown

This block watches a peak-current-limit flag from a power converter's current comparator and decides when a sustained overload has become a fault. A divider turns the clock into a fixed time tick. On every tick the block samples the flag. It adds one to a small net-overload count when the flag is high and takes one away when it is low. Repeated short overloads therefore build up toward a fault, while a single brief event decays away. When the count reaches its completion value, the block removes the gate-drive enable.

What happens after a shutdown depends on a static option pin. With the option set, the shutdown is permanent and only a full reset clears it. With the option clear, the block holds the drive off until the supply controller reports a fresh startup, and then resumes from a clean state. A second input, for winding short circuits, skips the timer and stops the drive on the next clock edge, under the same policy. All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `oft_overload_timer`

## Requirements
- R1: After reset, drive_en is 1, fault_o is 0 and latched_o is 0, and the net-overload count is zero.
- R2: A tick occurs once every TICK_CYCLES clock cycles, first in the TICK_CYCLES-th cycle after reset release or after an accepted restart. In a tick cycle the count rises by one if ovc_flag is 1 and falls by one if it is 0.
- R3: The count never drops below zero. Ticks with ovc_flag at 0 while the count is zero leave it at zero, so later overload ticks start from zero.
- R4: On the clock edge that ends the tick cycle carrying the LIMIT-th net up-count (LIMIT defaults to 8), drive_en goes to 0 and fault_o goes to 1. With fewer net up-counts, drive_en stays at 1.
- R5: If latch_sel is 1 at the moment of shutdown, latched_o goes to 1. The block then stays stopped until reset, and supply_restart has no effect.
- R6: If latch_sel is 0 at the moment of shutdown, latched_o stays 0 and the drive stays off until supply_restart is 1 for one cycle. The next edge then restores drive_en to 1, clears fault_o, the count and the tick phase.
- R7: When hard_stop is 1 while running, the drive stops on the next edge whatever the count, under the same latch_sel policy as an overload trip.
- R8: supply_restart while running has no effect on the outputs or on the count.
- R9: latch_sel is only sampled at the shutdown edge. Changing it while stopped does not change latched_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (models a full power cycle) |
| ovc_flag | input | 1 | Peak-current-limit comparator flag |
| hard_stop | input | 1 | Winding-short immediate stop request |
| latch_sel | input | 1 | 1 = latched shutdown, 0 = auto-recovery |
| supply_restart | input | 1 | One-cycle pulse marking a new startup after supply undervoltage |
| drive_en | output | 1 | Gate-drive enable |
| latched_o | output | 1 | Stopped permanently until reset |
| fault_o | output | 1 | A shutdown is in force |

## Verification
The hardest state to reach from the pins is a trip that follows interleaved overload and recovery ticks. In that case the count sits at seven after decays, or has rested at zero through several empty ticks, and the trip edge must land on exactly the right tick. Directed sequences place the flag on whole tick windows measured from reset: rise, partial decay, saturation at zero, then the final climb. A reference model, stepped each clock, follows long constrained-random runs with biased flag bursts, rare hard stops, restarts and option changes. These runs reach restart-during-run, option changes while stopped, and hard stops that coincide with a tick.

// File: rtl/oft_pkg.sv
package oft_pkg;

  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_HALT_AUTO  = 2'd1,
    ST_HALT_LATCH = 2'd2
  } oft_state_e;

endpackage

// File: rtl/oft_tick_gen.sv
module oft_tick_gen #(
  parameter int unsigned TICK_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr)    div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/oft_updown.sv
module oft_updown #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          tick,
  input  logic          up,
  output logic [CW-1:0] cnt,
  output logic          trip
);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] NEAR = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign trip = tick & up & ~hold & (cnt_q == NEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (!hold && tick) begin
      if (up) begin
        if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/oft_policy.sv
module oft_policy
  import oft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip,
  input  logic       hard_stop,
  input  logic       latch_sel,
  input  logic       restart,
  output oft_state_e state,
  output logic       restart_ok
);
  oft_state_e state_q, state_d;

  assign state      = state_q;
  assign restart_ok = (state_q == ST_HALT_AUTO) && restart;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:
        if (trip || hard_stop)
          state_d = latch_sel ? ST_HALT_LATCH : ST_HALT_AUTO;
      ST_HALT_AUTO:
        if (restart) state_d = ST_RUN;
      ST_HALT_LATCH:
        state_d = ST_HALT_LATCH;
      default:
        state_d = ST_HALT_LATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/oft_overload_timer.sv
module oft_overload_timer
  import oft_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int unsigned LIMIT       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovc_flag,
  input  logic hard_stop,
  input  logic latch_sel,
  input  logic supply_restart,
  output logic drive_en,
  output logic latched_o,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic          tick;
  logic          trip;
  logic          restart_ok;
  logic          halted;
  logic [CW-1:0] cnt;
  oft_state_e    state;

  assign halted = (state != ST_RUN);

  oft_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart_ok),
    .tick  (tick)
  );

  oft_updown #(.LIMIT(LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart_ok),
    .hold  (halted),
    .tick  (tick),
    .up    (ovc_flag),
    .cnt   (cnt),
    .trip  (trip)
  );

  oft_policy u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip       (trip),
    .hard_stop  (hard_stop),
    .latch_sel  (latch_sel),
    .restart    (supply_restart),
    .state      (state),
    .restart_ok (restart_ok)
  );

  assign drive_en  = (state == ST_RUN);
  assign fault_o   = halted;
  assign latched_o = (state == ST_HALT_LATCH);
endmodule

// File: rtl/oft_checker.sv
module oft_checker #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovc_flag,
  input logic          hard_stop,
  input logic          latch_sel,
  input logic          supply_restart,
  input logic          drive_en,
  input logic          latched_o,
  input logic          fault_o,
  input logic          tick,
  input logic [CW-1:0] cnt
);
  // R1: reset state checked at the first edge after release
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (drive_en && !fault_o && !latched_o && cnt == '0));

  // R2: an up tick below the trip point adds exactly one
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !hard_stop && tick && ovc_flag && cnt < CW'(LIMIT - 1))
      |=> (cnt == $past(cnt) + 1'b1));

  // R3: a down tick at zero keeps zero
  assert_floor_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !hard_stop && tick && !ovc_flag && cnt == '0) |=> (cnt == '0));

  // R4: a drive loss always comes with a fault indication
  assert_fall_means_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |-> fault_o);

  // R5: once latched, always latched until reset
  assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o |=> (latched_o && !drive_en));

  // R6: auto-recovery restart brings drive back
  assert_auto_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !latched_o && supply_restart) |=> (drive_en && !fault_o && cnt == '0));

  // R7: immediate stop takes effect on the next edge
  assert_hard_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && hard_stop) |=> (!drive_en && latched_o == $past(latch_sel)));

  // R9: the option pin does not alter a stop already in force
  assert_option_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !latched_o) |=> !latched_o);
endmodule

bind oft_overload_timer oft_checker #(.LIMIT(LIMIT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ovc_flag       (ovc_flag),
  .hard_stop      (hard_stop),
  .latch_sel      (latch_sel),
  .supply_restart (supply_restart),
  .drive_en       (drive_en),
  .latched_o      (latched_o),
  .fault_o        (fault_o),
  .tick           (tick),
  .cnt            (cnt)
);

// File: tb/sim_oft_overload_timer.sv
module sim_oft_overload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int LIMIT      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovc_flag = 1'b0, hard_stop = 1'b0, latch_sel = 1'b0, supply_restart = 1'b0;
  logic drive_en, latched_o, fault_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oft_overload_timer #(.TICK_CYCLES(TICK), .LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .ovc_flag(ovc_flag), .hard_stop(hard_stop),
    .latch_sel(latch_sel), .supply_restart(supply_restart),
    .drive_en(drive_en), .latched_o(latched_o), .fault_o(fault_o)
  );

  // reference model built from the requirements: 0 run, 1 auto stop, 2 latched stop
  int m_div = 0, m_cnt = 0, m_state = 0;

  function automatic int sat_step(int c, bit up);
    if (up) return (c < LIMIT) ? c + 1 : c;
    return (c > 0) ? c - 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_state = 0;
    end else begin
      bit tk;
      tk = (m_div == TICK - 1);
      if (m_state == 1 && supply_restart) begin
        m_state = 0; m_cnt = 0; m_div = 0;
      end else begin
        m_div = tk ? 0 : m_div + 1;
        if (m_state == 0) begin
          if (hard_stop || (tk && ovc_flag && m_cnt == LIMIT - 1))
            m_state = latch_sel ? 2 : 1;
          if (tk) m_cnt = sat_step(m_cnt, ovc_flag);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pack_out(logic d, logic l, logic f);
    return {29'd0, d, l, f};
  endfunction

  task automatic check_model(string req);
    int act, exp;
    act = pack_out(drive_en, latched_o, fault_o);
    exp = pack_out(m_state == 0, m_state == 2, m_state != 0);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ovc_flag = 0; hard_stop = 0; supply_restart = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_ticks(int n, bit flag);
    ovc_flag = flag;
    repeat (n * TICK) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(string req, bit d, bit l, bit f);
    int act, exp;
    act = pack_out(drive_en, latched_o, fault_o);
    exp = pack_out(d, l, f);
    check(act == exp, req, act, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0F7A));
    // R1 reset state
    do_reset();
    expect_out("R1", 1, 0, 0);

    // R2/R4: 7 overload ticks keep running, the 8th trips (auto mode)
    latch_sel = 0;
    run_ticks(7, 1);
    expect_out("R4 below limit", 1, 0, 0);
    run_ticks(1, 1);
    expect_out("R4 trip at 8", 0, 0, 1);
    check_model("R4 model");

    // R6: stays off until restart, restart clears
    run_ticks(3, 0);
    expect_out("R6 held off", 0, 0, 1);
    latch_sel = 1;  // R9: option change while stopped has no effect
    repeat (TICK) @(posedge clk);
    @(negedge clk);
    expect_out("R9 option frozen", 0, 0, 1);
    supply_restart = 1;
    @(negedge clk);
    supply_restart = 0;
    expect_out("R6 restart", 1, 0, 0);
    // count cleared by restart: 7 more ticks do not trip, 8th does (latched now)
    run_ticks(7, 1);
    expect_out("R6 count cleared", 1, 0, 0);
    run_ticks(1, 1);
    expect_out("R5 latched trip", 0, 1, 1);
    supply_restart = 1;
    @(negedge clk);
    supply_restart = 0;
    @(negedge clk);
    expect_out("R5 restart ignored", 0, 1, 1);

    // R3: decay at zero saturates
    do_reset();
    latch_sel = 0;
    run_ticks(3, 0);
    run_ticks(7, 1);
    expect_out("R3 floor then 7", 1, 0, 0);
    run_ticks(1, 1);
    expect_out("R3 floor then 8", 0, 0, 1);

    // R2: up 5, down 2, up 4 -> 7 net, then 1 more trips
    do_reset();
    run_ticks(5, 1);
    run_ticks(2, 0);
    run_ticks(4, 1);
    expect_out("R2 net seven", 1, 0, 0);
    run_ticks(1, 1);
    expect_out("R2 net eight", 0, 0, 1);

    // R8: restart while running has no effect on outputs or the count
    do_reset();
    run_ticks(4, 1);
    supply_restart = 1;
    @(negedge clk);
    supply_restart = 0;
    expect_out("R8 restart in run", 1, 0, 0);
    // tick phase is one cycle on; finish the current tick period then 4 more ticks
    ovc_flag = 1;
    repeat (4 * TICK - 1) @(posedge clk);
    @(negedge clk);
    expect_out("R8 count kept", 0, 0, 1);

    // R7: immediate stop with low count, both policies
    do_reset();
    latch_sel = 1;
    hard_stop = 1;
    @(negedge clk);
    hard_stop = 0;
    expect_out("R7 hard stop latched", 0, 1, 1);
    do_reset();
    latch_sel = 0;
    hard_stop = 1;
    @(negedge clk);
    hard_stop = 0;
    expect_out("R7 hard stop auto", 0, 0, 1);
    supply_restart = 1;
    @(negedge clk);
    supply_restart = 0;
    expect_out("R7 recovers", 1, 0, 0);

    // constrained random against the model
    for (int blk = 0; blk < 6; blk++) begin
      int bias;
      do_reset();
      bias = 40 + int'($urandom_range(40));
      for (int c = 0; c < 2500; c++) begin
        ovc_flag       = ($urandom_range(99) < bias);
        hard_stop      = ($urandom_range(599) == 0);
        supply_restart = ($urandom_range(59) == 0);
        if ($urandom_range(299) == 0) latch_sel = ~latch_sel;
        if ($urandom_range(199) == 0) bias = int'($urandom_range(100));
        @(negedge clk);
        check_model("R2 R4 R5 R6 R7 R8 R9 random");
      end
      latch_sel = (blk % 2 == 0);
      ovc_flag = 0; hard_stop = 0; supply_restart = 0;
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule